// File: doc/BRIEF.md
# Late-Transition Window Detector

This block watches the endpoint of one timing-critical path during a speed-binning test. It takes two samples of the path output: one when the functional capture strobe fires, and one when a later window strobe fires. The window strobe marks the end of the margin that a paired launch-clock adaptor can add. If the two samples differ, the path settled inside the recoverable window. The block then sets a sticky flag that can steer that adaptor.

Settling before capture leaves both samples equal, and so does settling after the window closes. A short pulse that returns to its old value before the window strobe also leaves them equal. None of these cases sets the flag. The window length between the two strobes must match the clock advance that the adaptor can give. All flags are cleared before a binning run starts, and an arm input keeps the block idle outside the test.

Top module: `lwd_top`

## Requirements
- R1: After reset, flag_o is 0 and no capture sample is pending.
- R2: When armed, a capture strobe stores path_d and leaves a sample pending. A later window strobe compares path_d against that sample. If they differ, flag_o reads 1 from the clock edge that sampled the window strobe onward.
- R3: If path_d already holds its final value at the capture strobe and keeps it through the window strobe (early settling), flag_o stays 0.
- R4: If path_d changes only after the window strobe (late settling), flag_o stays 0.
- R5: If path_d leaves its captured value and returns to it before the window strobe (a glitch), flag_o stays 0.
- R6: Once flag_o is 1, it remains 1 until clr is asserted. This holds through later matching windows and while disarmed.
- R7: A synchronous clr forces flag_o to 0 and discards any pending sample. clr takes priority over a mismatch in the same cycle.
- R8: While arm is 0, capture and window strobes are ignored and flag_o does not change. Lowering arm also discards a pending sample.
- R9: Each capture sample serves one window strobe. A window strobe with no pending sample never sets flag_o.
- R10: With a multi-bit path_d (width DW), a difference in any single bit between the two samples sets flag_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables detection during the binning test |
| clr | input | 1 | Synchronous clear of flag and pending sample |
| cap_stb | input | 1 | Functional capture strobe |
| win_stb | input | 1 | End-of-window sample strobe |
| path_d | input | DW | Monitored path endpoint value |
| flag_o | output | 1 | Sticky adaptable-late-transition flag |

## Verification
A corrupted captured sample or a stuck pending state shows up at flag_o. It gives a wrong value one clock after the next window strobe, either a false set on matching data or a missed set on differing data. A fault in the sticky register shows up within one cycle as flag_o dropping without clr, or not dropping after clr. The directed scenarios place each settling pattern around the two strobes and check flag_o on the cycle after the window strobe.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  typedef enum logic [0:0] {
    LWD_IDLE = 1'b0,
    LWD_PEND = 1'b1
  } lwd_state_e;
endpackage

// File: rtl/lwd_capture.sv
module lwd_capture
  import lwd_pkg::*;
#(
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          clr,
  input  logic          cap_stb,
  input  logic          win_stb,
  input  logic [DW-1:0] path_d,
  output logic          hit
);
  lwd_state_e    st_q, st_nxt;
  logic [DW-1:0] smp_q, smp_nxt;
  logic          smp_en;
  logic          diff;

  // A mismatch in any bit counts
  assign diff = |(smp_q ^ path_d);
  assign hit  = arm & ~clr & win_stb & (st_q == LWD_PEND) & diff;

  always_comb begin
    st_nxt  = st_q;
    smp_en  = 1'b0;
    smp_nxt = smp_q;
    if (clr || !arm) begin
      st_nxt = LWD_IDLE;
    end else if (cap_stb) begin
      smp_en  = 1'b1;
      smp_nxt = path_d;
      st_nxt  = LWD_PEND;
    end else if (win_stb) begin
      st_nxt = LWD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LWD_IDLE;
    end else begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else if (smp_en) begin
      smp_q <= smp_nxt;
    end
  end
endmodule

// File: rtl/lwd_sticky.sv
module lwd_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic flag
);
  logic flag_q, flag_nxt;

  always_comb begin
    if (clr) begin
      flag_nxt = 1'b0;
    end else begin
      flag_nxt = flag_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/lwd_top.sv
module lwd_top #(
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          clr,
  input  logic          cap_stb,
  input  logic          win_stb,
  input  logic [DW-1:0] path_d,
  output logic          flag_o
);
  logic hit;

  lwd_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .clr     (clr),
    .cap_stb (cap_stb),
    .win_stb (win_stb),
    .path_d  (path_d),
    .hit     (hit)
  );

  lwd_sticky u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .hit   (hit),
    .flag  (flag_o)
  );
endmodule

// File: rtl/lwd_chk.sv
module lwd_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic clr,
  input logic win_stb,
  input logic flag_o
);
  // R6: a raised flag holds unless cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr) |=> flag_o);

  // R7: clear forces the flag low
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_o);

  // R8: disarmed block never raises the flag
  a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !flag_o) |=> !flag_o);

  // R2: the flag rises only on a window strobe
  a_r2_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_stb && !flag_o) |=> !flag_o);

  // R1: outside reset the flag is never unknown
  a_r1_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(flag_o));
endmodule

bind lwd_top lwd_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .arm     (arm),
  .clr     (clr),
  .win_stb (win_stb),
  .flag_o  (flag_o)
);

// File: tb/lwd_top_test.sv
module lwd_top_test;
  localparam int DW = 4;

  logic          clk;
  logic          rst_n;
  logic          arm;
  logic          clr;
  logic          cap_stb;
  logic          win_stb;
  logic [DW-1:0] path_d;
  logic          flag_o;

  int checks;
  int errors;
  bit done;

  lwd_top #(.DW(DW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .clr     (clr),
    .cap_stb (cap_stb),
    .win_stb (win_stb),
    .path_d  (path_d),
    .flag_o  (flag_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flag_o=%b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; returns after the next falling edge
  task automatic cyc(input logic c, input logic w, input logic [DW-1:0] d,
                     input logic a = 1'b1, input logic cl = 1'b0);
    cap_stb = c;
    win_stb = w;
    path_d  = d;
    arm     = a;
    clr     = cl;
    @(negedge clk);
  endtask

  task automatic do_clr();
    cyc(1'b0, 1'b0, path_d, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, path_d);
  endtask

  // capture value, mid value, window value, value after window
  task automatic window(input logic [DW-1:0] dc, input logic [DW-1:0] dm,
                        input logic [DW-1:0] dw, input logic [DW-1:0] da);
    cyc(1'b1, 1'b0, dc);
    cyc(1'b0, 1'b0, dm);
    cyc(1'b0, 1'b1, dw);
    cyc(1'b0, 1'b0, da);
    cyc(1'b0, 1'b0, da);
  endtask

  task automatic t_reset();
    chk("R1 reset", flag_o, 1'b0);
    window(4'h0, 4'h0, 4'h0, 4'h0);
    chk("R1 no pending after reset", flag_o, 1'b0);
  endtask

  task automatic t_adapt();
    do_clr();
    cyc(1'b1, 1'b0, 4'h0);
    cyc(1'b0, 1'b0, 4'h0);
    cyc(1'b0, 1'b1, 4'h1);
    chk("R2 set on edge after window strobe", flag_o, 1'b1);
  endtask

  task automatic t_early();
    do_clr();
    window(4'h1, 4'h1, 4'h1, 4'h1);
    chk("R3 early settle", flag_o, 1'b0);
  endtask

  task automatic t_late();
    do_clr();
    window(4'h0, 4'h0, 4'h0, 4'h1);
    chk("R4 late settle", flag_o, 1'b0);
  endtask

  task automatic t_glitch();
    do_clr();
    window(4'h0, 4'h1, 4'h0, 4'h0);
    chk("R5 glitch", flag_o, 1'b0);
  endtask

  task automatic t_sticky();
    do_clr();
    window(4'h0, 4'h1, 4'h1, 4'h1);
    chk("R6 set", flag_o, 1'b1);
    window(4'h1, 4'h1, 4'h1, 4'h0);
    chk("R6 holds through matching window", flag_o, 1'b1);
    cyc(1'b1, 1'b0, 4'h0, 1'b0);
    cyc(1'b0, 1'b1, 4'h0, 1'b0);
    chk("R6 holds while disarmed", flag_o, 1'b1);
    do_clr();
    chk("R6 R7 cleared", flag_o, 1'b0);
  endtask

  task automatic t_clear_prio();
    do_clr();
    cyc(1'b1, 1'b0, 4'h0);
    cyc(1'b0, 1'b0, 4'h1);
    cyc(1'b0, 1'b1, 4'h1, 1'b1, 1'b1);
    chk("R7 clr beats mismatch", flag_o, 1'b0);
    cyc(1'b1, 1'b0, 4'h0);
    cyc(1'b0, 1'b0, 4'h0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 4'h1);
    cyc(1'b0, 1'b0, 4'h1);
    chk("R7 clr discards pending", flag_o, 1'b0);
  endtask

  task automatic t_disarm();
    do_clr();
    cyc(1'b1, 1'b0, 4'h0, 1'b0);
    cyc(1'b0, 1'b1, 4'h1, 1'b0);
    cyc(1'b0, 1'b0, 4'h1, 1'b0);
    chk("R8 disarmed ignored", flag_o, 1'b0);
    cyc(1'b1, 1'b0, 4'h0);
    cyc(1'b0, 1'b0, 4'h0, 1'b0);
    cyc(1'b0, 1'b1, 4'h1);
    cyc(1'b0, 1'b0, 4'h1);
    chk("R8 disarm drops pending", flag_o, 1'b0);
  endtask

  task automatic t_orphan();
    do_clr();
    window(4'h2, 4'h2, 4'h2, 4'h2);
    cyc(1'b0, 1'b1, 4'h5);
    cyc(1'b0, 1'b0, 4'h5);
    chk("R9 window without pending", flag_o, 1'b0);
  endtask

  task automatic t_multibit();
    for (int b = 0; b < DW; b++) begin
      do_clr();
      window(4'hA, 4'hA, 4'hA ^ (4'h1 << b), 4'hA);
      chk($sformatf("R10 bit %0d differs", b), flag_o, 1'b1);
    end
    do_clr();
    window(4'hF, 4'h0, 4'hF, 4'h0);
    chk("R10 all bits glitch", flag_o, 1'b0);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    arm     = 1'b0;
    clr     = 1'b0;
    cap_stb = 1'b0;
    win_stb = 1'b0;
    path_d  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_adapt();
    t_early();
    t_late();
    t_glitch();
    t_sticky();
    t_clear_prio();
    t_disarm();
    t_orphan();
    t_multibit();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule